// File: doc/BRIEF.md
# Fault capture interrupt status unit

This block collects two interrupt sources for a processor subsystem and shows them in one byte-wide status register. The first source is a bus fault reported by the processor's bus interface. The second is an interrupt-type timeout from the core watchdog. Each source has a sticky flag. Software clears a flag by writing a one to its bit. The watchdog flag drives its interrupt line directly. The bus-fault flag drives its interrupt line only while a separate enable bit is set.

When a bus fault occurs, the block also takes a snapshot of the failing access: its address, its attribute bits and, for a write, its data. The snapshot belongs to the first fault. It stays frozen until software clears the fault flag, so an interrupt handler always reads a consistent record of the fault that raised the flag.

Software reaches the block through a single-cycle register port with a combinational read path. The register offsets are: 0 status, 1 control, 2 captured address, 3 captured attributes, 4 captured write data. Offsets 5 to 7 read as zero.

Top module: `fault_irq_status`

## Requirements
- R1: After reset, the status register and the control register read zero, and both interrupt outputs are low.
- R2: At offset 0, bit 1 is the bus-fault flag and bit 0 is the watchdog flag. Bits 7 down to 2, and every higher bit of the read word, always read zero.
- R3: A `wdt_irq_pulse` sets the watchdog flag on the next clock edge. `irq_wdt` equals the watchdog flag at all times.
- R4: A write to offset 0 clears each flag whose bit in the write data is 1. A 0 in that bit leaves the flag unchanged, so writing 0x01 clears only the watchdog flag.
- R5: A `flt_valid` cycle sets the bus-fault flag on the next clock edge, whatever the state of the enable bit.
- R6: `irq_fault` is high exactly while both the bus-fault flag and the enable bit are set. If the flag is already set, `irq_fault` rises in the cycle after the write that sets the enable bit.
- R7: When a fault is captured, offset 2 reads the fault address and offset 3 reads the attributes, each zero-extended. Offset 4 reads the write data for a write fault and zero for a read fault.
- R8: A fault that arrives while the bus-fault flag is set, and is not cleared in that same cycle, leaves the captured address, attributes and data unchanged.
- R9: If a set event and a write-one clear of the same flag fall in one cycle, the flag ends up set. For the bus fault, the new fault is also captured.
- R10: Bit 0 of offset 1 is the read/write fault interrupt enable. The other bits of offset 1 ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | RDW | Register write data |
| reg_rdata | output | RDW | Register read data, combinational from `reg_addr` |
| flt_valid | input | 1 | Bus fault event, one cycle per fault |
| flt_write | input | 1 | The faulting access was a write |
| flt_addr | input | ADDR_W | Faulting address |
| flt_attr | input | ATTR_W | Access attributes of the faulting access |
| flt_wdata | input | DATA_W | Write data of the faulting access |
| wdt_irq_pulse | input | 1 | Watchdog timeout that is configured to interrupt |
| irq_fault | output | 1 | Bus-fault interrupt request |
| irq_wdt | output | 1 | Watchdog interrupt request |

## Verification
The bench builds the block with `ADDR_W` set to 24 and `ATTR_W` set to 5, keeping a 32-bit register port. With these values, any stray bits above the narrow capture fields show up in the zero-extension checks of the address and attribute reads. The directed scenarios cover these cases:
- a stale fault that raises the interrupt only once the enable is written;
- a second fault that hits a held capture;
- set and clear landing in the same cycle, for both flags at once;
- a read fault whose data readback must be zero.

// File: rtl/fisu_pkg.sv
package fisu_pkg;

    typedef enum logic [2:0] {
        OFF_STATUS = 3'd0,
        OFF_CTRL   = 3'd1,
        OFF_ADDR   = 3'd2,
        OFF_ATTR   = 3'd3,
        OFF_DATA   = 3'd4
    } reg_off_e;

    localparam int unsigned NSRC    = 2;
    localparam int unsigned WDT_BIT = 0;
    localparam int unsigned FLT_BIT = 1;
    localparam int unsigned STAT_W  = 8;

endpackage

// File: rtl/fisu_flag.sv
module fisu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/fisu_capture.sv
module fisu_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              is_write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
        logic [DATA_W-1:0] data;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = addr_i;
            st_d.attr = attr_i;
            st_d.data = is_write_i ? data_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign attr_o = st_q.attr;
    assign data_o = st_q.data;

endmodule

// File: rtl/fisu_regif.sv
module fisu_regif
    import fisu_pkg::*;
#(
    parameter int unsigned RDW    = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [RDW-1:0]    reg_wdata,
    input  logic [NSRC-1:0]   flags_i,
    input  logic [ADDR_W-1:0] cap_addr_i,
    input  logic [ATTR_W-1:0] cap_attr_i,
    input  logic [DATA_W-1:0] cap_data_i,
    output logic [NSRC-1:0]   clr_o,
    output logic              en_o,
    output logic [RDW-1:0]    reg_rdata
);

    typedef struct packed {
        logic en;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (reg_wr) begin
            case (reg_off_e'(reg_addr))
                OFF_STATUS: clr_o = reg_wdata[NSRC-1:0];
                OFF_CTRL:   st_d.en = reg_wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_off_e'(reg_addr))
            OFF_STATUS: reg_rdata[NSRC-1:0]   = flags_i;
            OFF_CTRL:   reg_rdata[0]          = st_q.en;
            OFF_ADDR:   reg_rdata[ADDR_W-1:0] = cap_addr_i;
            OFF_ATTR:   reg_rdata[ATTR_W-1:0] = cap_attr_i;
            OFF_DATA:   reg_rdata[DATA_W-1:0] = cap_data_i;
            default:    reg_rdata = '0;
        endcase
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/fault_irq_status.sv
module fault_irq_status
    import fisu_pkg::*;
#(
    parameter int unsigned RDW    = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [RDW-1:0]    reg_wdata,
    output logic [RDW-1:0]    reg_rdata,
    input  logic              flt_valid,
    input  logic              flt_write,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [ATTR_W-1:0] flt_attr,
    input  logic [DATA_W-1:0] flt_wdata,
    input  logic              wdt_irq_pulse,
    output logic              irq_fault,
    output logic              irq_wdt
);

    logic [NSRC-1:0]   set_v;
    logic [NSRC-1:0]   clr_v;
    logic [NSRC-1:0]   flag_q;
    logic              en_q;
    logic              cap_load;
    logic [ADDR_W-1:0] cap_addr;
    logic [ATTR_W-1:0] cap_attr;
    logic [DATA_W-1:0] cap_data;

    always_comb begin
        set_v          = '0;
        set_v[WDT_BIT] = wdt_irq_pulse;
        set_v[FLT_BIT] = flt_valid;
        cap_load       = flt_valid && (!flag_q[FLT_BIT] || clr_v[FLT_BIT]);
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        fisu_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .flag_o (flag_q[i])
        );
    end

    fisu_capture #(
        .ADDR_W (ADDR_W),
        .ATTR_W (ATTR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cap_load),
        .is_write_i (flt_write),
        .addr_i     (flt_addr),
        .attr_i     (flt_attr),
        .data_i     (flt_wdata),
        .addr_o     (cap_addr),
        .attr_o     (cap_attr),
        .data_o     (cap_data)
    );

    fisu_regif #(
        .RDW    (RDW),
        .ADDR_W (ADDR_W),
        .ATTR_W (ATTR_W),
        .DATA_W (DATA_W)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .flags_i    (flag_q),
        .cap_addr_i (cap_addr),
        .cap_attr_i (cap_attr),
        .cap_data_i (cap_data),
        .clr_o      (clr_v),
        .en_o       (en_q),
        .reg_rdata  (reg_rdata)
    );

    assign irq_fault = flag_q[FLT_BIT] & en_q;
    assign irq_wdt   = flag_q[WDT_BIT];

endmodule

// File: rtl/fisu_chk.sv
module fisu_chk
    import fisu_pkg::*;
#(
    parameter int unsigned RDW    = 32,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [RDW-1:0]    reg_wdata,
    input logic [RDW-1:0]    reg_rdata,
    input logic              flt_valid,
    input logic              wdt_irq_pulse,
    input logic              irq_fault,
    input logic              irq_wdt,
    input logic [NSRC-1:0]   flag_q,
    input logic              en_q,
    input logic [ADDR_W-1:0] cap_addr
);

    logic clr_flt_wr;
    logic clr_wdt_wr;
    assign clr_flt_wr = reg_wr && reg_addr == 3'(OFF_STATUS) && reg_wdata[FLT_BIT];
    assign clr_wdt_wr = reg_wr && reg_addr == 3'(OFF_STATUS) && reg_wdata[WDT_BIT];

    // R2
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 3'(OFF_STATUS) |-> reg_rdata[RDW-1:NSRC] == '0);

    // R3
    wdt_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq_pulse |=> irq_wdt);

    // R4
    wdt_zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wdt_wr && !wdt_irq_pulse) |=> $stable(irq_wdt));

    // R5
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> flag_q[FLT_BIT]);

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_fault);

    // R8
    capture_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[FLT_BIT] && !clr_flt_wr) |=> $stable(cap_addr));

endmodule

bind fault_irq_status fisu_chk #(
    .RDW    (RDW),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .flt_valid     (flt_valid),
    .wdt_irq_pulse (wdt_irq_pulse),
    .irq_fault     (irq_fault),
    .irq_wdt       (irq_wdt),
    .flag_q        (flag_q),
    .en_q          (en_q),
    .cap_addr      (cap_addr)
);

// File: tb/fault_irq_status_tb.sv
module fault_irq_status_tb_top;

    localparam int unsigned RDW    = 32;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned ATTR_W = 5;
    localparam int unsigned DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [RDW-1:0]    reg_wdata = '0;
    logic [RDW-1:0]    reg_rdata;
    logic              flt_valid = 1'b0;
    logic              flt_write = 1'b0;
    logic [ADDR_W-1:0] flt_addr = '0;
    logic [ATTR_W-1:0] flt_attr = '0;
    logic [DATA_W-1:0] flt_wdata = '0;
    logic              wdt_irq_pulse = 1'b0;
    logic              irq_fault;
    logic              irq_wdt;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    fault_irq_status #(
        .RDW(RDW), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
        .flt_write(flt_write), .flt_addr(flt_addr), .flt_attr(flt_attr),
        .flt_wdata(flt_wdata), .wdt_irq_pulse(wdt_irq_pulse),
        .irq_fault(irq_fault), .irq_wdt(irq_wdt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] off, output logic [RDW-1:0] v);
        reg_addr = off;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] off, input logic [RDW-1:0] v);
        reg_addr = off; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic fault(input logic w, input logic [ADDR_W-1:0] a,
                         input logic [ATTR_W-1:0] t, input logic [DATA_W-1:0] d);
        flt_valid = 1'b1; flt_write = w; flt_addr = a; flt_attr = t; flt_wdata = d;
        @(posedge clk); @(negedge clk);
        flt_valid = 1'b0; flt_write = 1'b0;
    endtask

    task automatic t_reset();
        logic [RDW-1:0] v;
        rd(3'd0, v); chk("R1 status", v, 32'h0);
        rd(3'd1, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 irq_fault", 32'(irq_fault), 32'h0);
        chk("R1 irq_wdt", 32'(irq_wdt), 32'h0);
    endtask

    task automatic t_wdt();
        logic [RDW-1:0] v;
        wdt_irq_pulse = 1'b1; @(posedge clk); @(negedge clk); wdt_irq_pulse = 1'b0;
        chk("R3 irq_wdt after pulse", 32'(irq_wdt), 32'h1);
        rd(3'd0, v); chk("R2 status wdt bit0", v, 32'h1);
        wr(3'd0, 32'hFFFF_FFFC);
        chk("R4 zero bits keep wdt flag", 32'(irq_wdt), 32'h1);
        wr(3'd0, 32'h1);
        chk("R4 write 0x01 clears wdt", 32'(irq_wdt), 32'h0);
    endtask

    task automatic t_stale_fault();
        logic [RDW-1:0] v;
        fault(1'b1, 24'hA5_1234, 5'h13, 32'hDEAD_BEEF);
        rd(3'd0, v); chk("R5 fault flag set while disabled", v, 32'h2);
        chk("R6 no irq while disabled", 32'(irq_fault), 32'h0);
        rd(3'd2, v); chk("R7 captured address", v, 32'h00A5_1234);
        rd(3'd3, v); chk("R7 captured attributes", v, 32'h13);
        rd(3'd4, v); chk("R7 captured write data", v, 32'hDEAD_BEEF);
        wr(3'd1, 32'hFFFF_FFFF);
        chk("R6 stale fault irq after enable", 32'(irq_fault), 32'h1);
        rd(3'd1, v); chk("R10 ctrl only bit0", v, 32'h1);
        fault(1'b0, 24'h11_1111, 5'h02, 32'h5555_5555);
        rd(3'd2, v); chk("R8 address held", v, 32'h00A5_1234);
        rd(3'd4, v); chk("R8 data held", v, 32'hDEAD_BEEF);
        wr(3'd0, 32'h1);
        chk("R4 wdt-only write keeps fault irq", 32'(irq_fault), 32'h1);
        wr(3'd0, 32'h2);
        chk("R4 clear fault drops irq", 32'(irq_fault), 32'h0);
        rd(3'd0, v); chk("R4 status after clear", v, 32'h0);
    endtask

    task automatic t_read_fault();
        logic [RDW-1:0] v;
        fault(1'b0, 24'hFF_FFFF, 5'h1F, 32'h1234_5678);
        rd(3'd4, v); chk("R7 read fault data zero", v, 32'h0);
        rd(3'd2, v); chk("R7 address zero-extended", v, 32'h00FF_FFFF);
        rd(3'd3, v); chk("R7 attr zero-extended", v, 32'h1F);
        rd(3'd5, v); chk("R2 unused offset zero", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [RDW-1:0] v;
        wdt_irq_pulse = 1'b1; @(posedge clk); @(negedge clk); wdt_irq_pulse = 1'b0;
        reg_addr = 3'd0; reg_wdata = 32'h3; reg_wr = 1'b1;
        flt_valid = 1'b1; flt_write = 1'b1; flt_addr = 24'h00_0042;
        flt_attr = 5'h07; flt_wdata = 32'hCAFE_F00D; wdt_irq_pulse = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; flt_valid = 1'b0; flt_write = 1'b0; wdt_irq_pulse = 1'b0;
        rd(3'd0, v); chk("R9 set wins both flags", v, 32'h3);
        rd(3'd2, v); chk("R9 new fault captured", v, 32'h0000_0042);
        rd(3'd4, v); chk("R9 new fault data", v, 32'hCAFE_F00D);
        wr(3'd1, 32'h0);
        chk("R10 enable cleared drops irq", 32'(irq_fault), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wdt();
        t_stale_fault();
        t_read_fault();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired R1 actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule